// File: doc/BRIEF.md
# Dual-Port Serial Configuration Register Controller

This block holds a bank of 32 configuration registers, each 10 bits wide, and gives two serial hosts access to them. The data-path port shares its wires with a streaming data path. The control port is a dedicated control channel. Each port carries 16-bit command words, and a frame-sync pulse marks the start of each word. A command names a register, says whether to read or write it, and for a write carries the new value. The reply to each command goes out on the same port during the next frame.

Two live status inputs restrict what may happen. While a receive burst is running, the data-path port is limited to writes. While a transmit burst is running, neither port may touch the uplink-section registers. These occupy a parameterised address window. A command that breaks either rule is refused. A refused command changes no register and returns an all-zero reply. It also sets a sticky violation flag for the port that sent it. The registers drive the rest of the chip through a flat output bus.

Top module: `dual_sreg_ctrl`

## Requirements
- R1: A command word is 16 bits long. Bit 0 selects the direction (0 = write, 1 = read), bits 5:1 hold the register address and bits 15:6 hold the payload. Bits arrive MSB first, sampled on rising bit-clock edges. The first bit is the one whose rising edge sees frame-sync high.
- R2: A permitted write stores its payload in the addressed register, visible in `cfg_q[addr*10 +: 10]`. No register changes unless a word completes.
- R3: The reply to each word is shifted out MSB first during the next frame on the same port, one bit after each rising edge. A permitted read replies with {value, address, 1'b1}, packed as value in bits 15:6, address in bits 5:1 and 1 in bit 0. A permitted write replies with all zeros.
- R4: While `rx_burst` is 1, a read on the data-path port is refused.
- R5: The control port is never refused because of `rx_burst`.
- R6: While `tx_burst` is 1, any read or write on either port to an address from UL_LO to UL_HI (default 16 to 23) is refused. Addresses outside that window are unaffected.
- R7: A refused command leaves every register unchanged and replies with all zeros. It also sets that port's violation output, which stays at 1 until reset.
- R8: If both ports write the same register in the same word cycle, the control port's value is kept. Writes to different registers in the same word cycle both take effect.
- R9: After reset, all registers are zero, both violation outputs are 0 and the first reply on each port is all zeros.
- R10: The payload bits of a read command have no effect on any register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all serial inputs are oversampled by it |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_burst | input | 1 | Receive burst in progress (data-path port limited to writes) |
| tx_burst | input | 1 | Transmit burst in progress (uplink window locked) |
| dp_sclk | input | 1 | Data-path port bit clock |
| dp_fsync | input | 1 | Data-path port frame sync |
| dp_sdi | input | 1 | Data-path port serial command in |
| dp_sdo | output | 1 | Data-path port serial reply out |
| cp_sclk | input | 1 | Control port bit clock |
| cp_fsync | input | 1 | Control port frame sync |
| cp_sdi | input | 1 | Control port serial command in |
| cp_sdo | output | 1 | Control port serial reply out |
| dp_viol | output | 1 | Sticky refusal flag, data-path port |
| cp_viol | output | 1 | Sticky refusal flag, control port |
| cfg_q | output | 320 | All register contents, register n in bits n*10+9 : n*10 |

## Verification
The bound checker watches the rules on every clock cycle. Registers must hold still when no word completes, and a data-path read during a receive burst must raise the violation flag. Control-port commands outside a transmit burst must never touch the flag, and a write into the locked window must change nothing. Violation flags must stay sticky, and the control port must win a same-address write race. The serial format and bit ordering can only be shown by the bench's frame scenarios. So can the one-frame reply latency, the echoed address and the register-by-register outcome of each status-flag combination. The bench sweeps every address, both directions and both ports under all four flag settings, and predicts each reply arithmetically.

// File: rtl/sra_pkg.sv
// Package: shared widths, command layout and access classification
// for the dual-port serial configuration register controller.
package sra_pkg;
    localparam int ADDR_W = 5;
    localparam int DATA_W = 10;
    localparam int WORD_W = 1 + ADDR_W + DATA_W;
    localparam int CNT_W  = $clog2(WORD_W + 1);
    localparam int NUM_REGS = 1 << ADDR_W;

    // Field order is fixed by the serial format: payload high, flag low.
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [ADDR_W-1:0] addr;
        logic              rd;
    } cmd_t;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_READ  = 2'd2,
        ACC_DENY  = 2'd3
    } acc_e;
endpackage

// File: rtl/sra_ser_port.sv
// Module: sra_ser_port
// One serial host port. Brings bit clock, frame sync and data into the
// clk domain, detects rising bit-clock edges, then assembles 16-bit
// commands and shifts replies out MSB first.
// Assumes: the bit clock is several clk periods per phase, and frame
// sync and data are stable around each rising bit-clock edge.
module sra_ser_port
    import sra_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              fsync_i,
    input  logic              sdi_i,
    output logic              sdo_o,
    output logic              word_vld_o,
    output logic [WORD_W-1:0] word_o,
    input  logic              tx_load_i,
    input  logic [WORD_W-1:0] tx_word_i
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

    logic [2:0]        raw;
    logic [2:0]        smp;
    logic              sclk_q;
    logic              bit_rise;
    logic [WORD_W-1:0] rx_sr;
    logic [WORD_W-1:0] rx_dr;
    logic [CNT_W-1:0]  rx_cnt;
    logic              vld_q;
    logic [WORD_W-1:0] tx_dr;
    logic [WORD_W-1:0] tx_sr;
    logic [CNT_W-1:0]  tx_cnt;

    assign raw = {sclk_i, fsync_i, sdi_i};

    generate
        if (SYNC_STAGES == 0) begin : g_nosync
            assign smp = raw;
        end else begin : g_sync
            logic [2:0] chain [SYNC_STAGES];
            // Purpose: synchronizer chain carrying all three pins together.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < SYNC_STAGES; i++) chain[i] <= '0;
                end else begin
                    chain[0] <= raw;
                    for (int i = 1; i < SYNC_STAGES; i++) chain[i] <= chain[i-1];
                end
            end
            assign smp = chain[SYNC_STAGES-1];
        end
    endgenerate

    // Purpose: remember the previous bit-clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= smp[2];
    end

    assign bit_rise = smp[2] & ~sclk_q;

    // Purpose: receive shift register, bit counter and receive data register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_sr  <= '0;
            rx_dr  <= '0;
            rx_cnt <= '0;
            vld_q  <= 1'b0;
        end else begin
            vld_q <= 1'b0;
            if (rx_cnt == FULL) begin
                rx_dr  <= rx_sr;
                vld_q  <= 1'b1;
                rx_cnt <= '0;
            end
            if (bit_rise) begin
                if (smp[1]) begin
                    rx_sr  <= {{(WORD_W-1){1'b0}}, smp[0]};
                    rx_cnt <= CNT_W'(1);
                end else if (rx_cnt != '0 && rx_cnt < FULL) begin
                    rx_sr  <= {rx_sr[WORD_W-2:0], smp[0]};
                    rx_cnt <= rx_cnt + 1'b1;
                end
            end
        end
    end

    // Purpose: transmit data register holding the reply for the next frame.
    always_ff @(posedge clk) begin
        if (!rst_n)         tx_dr <= '0;
        else if (tx_load_i) tx_dr <= tx_word_i;
    end

    // Purpose: transmit shift register and its bit counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sr  <= '0;
            tx_cnt <= '0;
        end else if (bit_rise) begin
            if (smp[1]) begin
                tx_sr  <= tx_dr;
                tx_cnt <= CNT_W'(1);
            end else if (tx_cnt != '0 && tx_cnt < FULL) begin
                tx_sr  <= {tx_sr[WORD_W-2:0], 1'b0};
                tx_cnt <= tx_cnt + 1'b1;
            end else begin
                tx_sr  <= '0;
                tx_cnt <= '0;
            end
        end
    end

    assign sdo_o      = tx_sr[WORD_W-1];
    assign word_vld_o = vld_q;
    assign word_o     = rx_dr;
endmodule

// File: rtl/sra_access_gate.sv
// Module: sra_access_gate
// Classifies one completed command as write, read or refused. It applies
// the live burst lockouts: the uplink window is locked during a transmit
// burst, and on the data-path port reads are locked during a receive burst.
// Assumes: UL_LO <= UL_HI and both fit in the address width.
module sra_access_gate
    import sra_pkg::*;
#(
    parameter int UL_LO     = 16,
    parameter int UL_HI     = 23,
    parameter bit DATA_PATH = 1'b0
) (
    input  logic vld_i,
    input  cmd_t cmd_i,
    input  logic rx_burst_i,
    input  logic tx_burst_i,
    output acc_e acc_o
);
    localparam logic [ADDR_W-1:0] LO = ADDR_W'(UL_LO);
    localparam logic [ADDR_W-1:0] HI = ADDR_W'(UL_HI);

    logic in_window;
    logic win_lock;
    logic rd_lock;
    logic [DATA_W-1:0] unused_data;

    assign unused_data = cmd_i.data;
    assign in_window = (cmd_i.addr >= LO) && (cmd_i.addr <= HI);
    assign win_lock  = tx_burst_i && in_window;
    assign rd_lock   = DATA_PATH && rx_burst_i && cmd_i.rd;

    // Purpose: pick the access class for this cycle.
    always_comb begin
        if (!vld_i)                 acc_o = ACC_NONE;
        else if (win_lock || rd_lock) acc_o = ACC_DENY;
        else if (cmd_i.rd)          acc_o = ACC_READ;
        else                        acc_o = ACC_WRITE;
    end
endmodule

// File: rtl/sra_reg_bank.sv
// Module: sra_reg_bank
// The configuration register array with two write ports and two read
// ports. Port B (control) has priority over port A (data path) when both
// write the same register. Reads return the value before this edge.
module sra_reg_bank
    import sra_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       a_we,
    input  logic [ADDR_W-1:0]          a_addr,
    input  logic [DATA_W-1:0]          a_wdata,
    output logic [DATA_W-1:0]          a_rdata,
    input  logic                       b_we,
    input  logic [ADDR_W-1:0]          b_addr,
    input  logic [DATA_W-1:0]          b_wdata,
    output logic [DATA_W-1:0]          b_rdata,
    output logic [NUM_REGS*DATA_W-1:0] flat_o
);
    logic [DATA_W-1:0] regs [NUM_REGS];

    generate
        for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
            // Purpose: one register, control port first.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    regs[g] <= '0;
                else if (b_we && b_addr == ADDR_W'(g))
                    regs[g] <= b_wdata;
                else if (a_we && a_addr == ADDR_W'(g))
                    regs[g] <= a_wdata;
            end
            assign flat_o[g*DATA_W +: DATA_W] = regs[g];
        end
    endgenerate

    assign a_rdata = regs[a_addr];
    assign b_rdata = regs[b_addr];
endmodule

// File: rtl/dual_sreg_ctrl.sv
// Module: dual_sreg_ctrl
// Top level: two serial ports (index 0 = data path, 1 = control), a
// gate per port, the shared register bank, reply formation and sticky
// refusal flags.
// Assumes: rx_burst and tx_burst are synchronous to clk.
module dual_sreg_ctrl
    import sra_pkg::*;
#(
    parameter int UL_LO       = 16,
    parameter int UL_HI       = 23,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rx_burst,
    input  logic                       tx_burst,
    input  logic                       dp_sclk,
    input  logic                       dp_fsync,
    input  logic                       dp_sdi,
    output logic                       dp_sdo,
    input  logic                       cp_sclk,
    input  logic                       cp_fsync,
    input  logic                       cp_sdi,
    output logic                       cp_sdo,
    output logic                       dp_viol,
    output logic                       cp_viol,
    output logic [NUM_REGS*DATA_W-1:0] cfg_q
);
    localparam int PORTS = 2;

    logic [PORTS-1:0] sclk_v;
    logic [PORTS-1:0] fsync_v;
    logic [PORTS-1:0] sdi_v;
    logic [PORTS-1:0] sdo_v;
    logic [PORTS-1:0] vld_v;
    logic [PORTS-1:0] we_v;
    logic [PORTS-1:0] viol_v;
    cmd_t             cmd_v   [PORTS];
    acc_e             acc_v   [PORTS];
    logic [DATA_W-1:0] rdata_v [PORTS];

    assign sclk_v  = {cp_sclk, dp_sclk};
    assign fsync_v = {cp_fsync, dp_fsync};
    assign sdi_v   = {cp_sdi, dp_sdi};

    generate
        for (genvar p = 0; p < PORTS; p++) begin : g_port
            logic [WORD_W-1:0] word;
            logic [WORD_W-1:0] reply;
            logic              viol_r;

            sra_ser_port #(.SYNC_STAGES(SYNC_STAGES)) u_ser (
                .clk        (clk),
                .rst_n      (rst_n),
                .sclk_i     (sclk_v[p]),
                .fsync_i    (fsync_v[p]),
                .sdi_i      (sdi_v[p]),
                .sdo_o      (sdo_v[p]),
                .word_vld_o (vld_v[p]),
                .word_o     (word),
                .tx_load_i  (vld_v[p]),
                .tx_word_i  (reply)
            );

            assign cmd_v[p] = cmd_t'(word);

            sra_access_gate #(
                .UL_LO     (UL_LO),
                .UL_HI     (UL_HI),
                .DATA_PATH (p == 0)
            ) u_gate (
                .vld_i      (vld_v[p]),
                .cmd_i      (cmd_v[p]),
                .rx_burst_i (rx_burst),
                .tx_burst_i (tx_burst),
                .acc_o      (acc_v[p])
            );

            assign we_v[p] = (acc_v[p] == ACC_WRITE);

            // Purpose: reply word, register value plus echo on a granted read.
            always_comb begin
                if (acc_v[p] == ACC_READ)
                    reply = {rdata_v[p], cmd_v[p].addr, 1'b1};
                else
                    reply = '0;
            end

            // Purpose: sticky refusal flag, cleared only by reset.
            always_ff @(posedge clk) begin
                if (!rst_n)                  viol_r <= 1'b0;
                else if (acc_v[p] == ACC_DENY) viol_r <= 1'b1;
            end
            assign viol_v[p] = viol_r;
        end
    endgenerate

    sra_reg_bank u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .a_we    (we_v[0]),
        .a_addr  (cmd_v[0].addr),
        .a_wdata (cmd_v[0].data),
        .a_rdata (rdata_v[0]),
        .b_we    (we_v[1]),
        .b_addr  (cmd_v[1].addr),
        .b_wdata (cmd_v[1].data),
        .b_rdata (rdata_v[1]),
        .flat_o  (cfg_q)
    );

    assign dp_sdo  = sdo_v[0];
    assign cp_sdo  = sdo_v[1];
    assign dp_viol = viol_v[0];
    assign cp_viol = viol_v[1];
endmodule

// File: rtl/sra_chk.sv
// Module: sra_chk
// Checker bound to dual_sreg_ctrl. It watches completed commands against
// the lockout, stickiness and priority rules on every clock.
module sra_chk
    import sra_pkg::*;
#(
    parameter int UL_LO = 16,
    parameter int UL_HI = 23
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       rx_burst,
    input logic                       tx_burst,
    input logic                       dp_vld,
    input logic                       cp_vld,
    input cmd_t                       dp_cmd,
    input cmd_t                       cp_cmd,
    input logic                       dp_viol,
    input logic                       cp_viol,
    input logic [NUM_REGS*DATA_W-1:0] cfg_q
);
    logic              cp_in_win;
    logic [ADDR_W-1:0] last_cp_addr;
    logic [DATA_W-1:0] won_field;
    logic              same_wr;

    assign cp_in_win = (int'(cp_cmd.addr) >= UL_LO) && (int'(cp_cmd.addr) <= UL_HI);
    assign same_wr   = dp_vld && cp_vld && !dp_cmd.rd && !cp_cmd.rd
                       && (dp_cmd.addr == cp_cmd.addr) && !tx_burst;

    // Purpose: remember the control port address to look up its field later.
    always_ff @(posedge clk) begin
        if (!rst_n) last_cp_addr <= '0;
        else        last_cp_addr <= cp_cmd.addr;
    end

    assign won_field = cfg_q[last_cp_addr*DATA_W +: DATA_W];

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!dp_vld && !cp_vld) |=> $stable(cfg_q)); // R2
    AST_DP_READ_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (dp_vld && rx_burst && dp_cmd.rd) |=> dp_viol); // R4
    AST_CP_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (cp_vld && !tx_burst) |=> $stable(cp_viol)); // R5
    AST_WIN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_burst && cp_vld && !cp_cmd.rd && cp_in_win && !dp_vld) |=> $stable(cfg_q)); // R6
    AST_DP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        dp_viol |=> dp_viol); // R7
    AST_CP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        cp_viol |=> cp_viol); // R7
    AST_CP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        same_wr |=> (won_field == $past(cp_cmd.data))); // R8
endmodule

bind dual_sreg_ctrl sra_chk #(.UL_LO(UL_LO), .UL_HI(UL_HI)) u_sra_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_burst (rx_burst),
    .tx_burst (tx_burst),
    .dp_vld   (vld_v[0]),
    .cp_vld   (vld_v[1]),
    .dp_cmd   (cmd_v[0]),
    .cp_cmd   (cmd_v[1]),
    .dp_viol  (dp_viol),
    .cp_viol  (cp_viol),
    .cfg_q    (cfg_q)
);

// File: tb/test_dual_sreg_ctrl.sv
// Bench: sweeps every address, both directions and both ports under all
// four burst-flag settings, and predicts replies, flags and register
// contents from the requirements.
module test_dual_sreg_ctrl;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         rx_burst = 1'b0, tx_burst = 1'b0;
    logic         dp_sclk = 1'b0, dp_fsync = 1'b0, dp_sdi = 1'b0;
    logic         cp_sclk = 1'b0, cp_fsync = 1'b0, cp_sdi = 1'b0;
    logic         dp_sdo, cp_sdo, dp_viol, cp_viol;
    logic [319:0] cfg_q;

    int n_chk = 0;
    int n_fail = 0;
    logic [9:0]  model [32];
    logic [15:0] exp_rep [2];
    logic        exp_viol [2];

    always #5 clk = ~clk;

    dual_sreg_ctrl i_dual_sreg_ctrl (
        .clk(clk), .rst_n(rst_n), .rx_burst(rx_burst), .tx_burst(tx_burst),
        .dp_sclk(dp_sclk), .dp_fsync(dp_fsync), .dp_sdi(dp_sdi), .dp_sdo(dp_sdo),
        .cp_sclk(cp_sclk), .cp_fsync(cp_fsync), .cp_sdi(cp_sdi), .cp_sdo(cp_sdo),
        .dp_viol(dp_viol), .cp_viol(cp_viol), .cfg_q(cfg_q)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 32; i++) model[i] = '0;
        exp_rep[0] = '0; exp_rep[1] = '0;
        exp_viol[0] = 1'b0; exp_viol[1] = 1'b0;
    endtask

    // Both ports clocked together; only enabled ports get a frame sync.
    task automatic frame2(input bit ea, input bit eb, input logic [15:0] wa, input logic [15:0] wb,
                          output logic [15:0] ra, output logic [15:0] rb);
        ra = '0; rb = '0;
        for (int k = 0; k < 16; k++) begin
            dp_fsync = ea && (k == 0);
            cp_fsync = eb && (k == 0);
            dp_sdi = wa[15-k];
            cp_sdi = wb[15-k];
            repeat (3) @(negedge clk);
            dp_sclk = 1'b1; cp_sclk = 1'b1;
            repeat (4) @(negedge clk);
            ra[15-k] = dp_sdo;
            rb[15-k] = cp_sdo;
            dp_sclk = 1'b0; cp_sclk = 1'b0;
        end
        dp_fsync = 1'b0; cp_fsync = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    function automatic bit allowed(input int port, input bit rd, input int addr, input bit rx, input bit tx);
        bit win_lock = tx && addr >= 16 && addr <= 23;
        bit rd_lock  = (port == 0) && rx && rd;
        return !(win_lock || rd_lock);
    endfunction

    function automatic logic [319:0] model_flat();
        logic [319:0] f;
        for (int i = 0; i < 32; i++) f[i*10 +: 10] = model[i];
        return f;
    endfunction

    // One command on one port, with all predictions applied afterwards.
    task automatic cmd1(input int port, input bit rd, input int addr, input logic [9:0] data);
        logic [15:0] w, ra, rb, got;
        bit ok;
        w = {data, addr[4:0], rd};
        if (port == 0) frame2(1'b1, 1'b0, w, 16'h0, ra, rb);
        else           frame2(1'b0, 1'b1, 16'h0, w, ra, rb);
        got = (port == 0) ? ra : rb;
        chk(got == exp_rep[port], (exp_rep[port] == 0) ? "R3/R7 zero reply" : "R3 read reply",
            32'(got), 32'(exp_rep[port]));
        ok = allowed(port, rd, addr, rx_burst, tx_burst);
        if (!ok) begin
            exp_viol[port] = 1'b1;
            exp_rep[port] = '0;
        end else if (rd) begin
            exp_rep[port] = {model[addr], addr[4:0], 1'b1};
        end else begin
            model[addr] = data;
            exp_rep[port] = '0;
        end
        chk(cfg_q == model_flat(), rd ? "R10/R2 registers" : "R2/R6 registers", 32'(cfg_q[31:0]), 32'(model_flat()));
        got = {15'b0, (port == 0) ? dp_viol : cp_viol};
        chk(got[0] == exp_viol[port], (port == 0) ? "R4/R6/R7 dp_viol" : "R5/R6/R7 cp_viol",
            32'(got), 32'(exp_viol[port]));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] ra, rb;
        do_reset();
        @(negedge clk);
        chk(cfg_q == '0, "R9 registers zero", 32'(cfg_q[31:0]), 0);
        chk(!dp_viol && !cp_viol, "R9 flags clear", {30'b0, dp_viol, cp_viol}, 0);
        chk(!dp_sdo && !cp_sdo, "R9 sdo low", {30'b0, dp_sdo, cp_sdo}, 0);

        // R1 R3 R4 R5 R6: every flag setting, port, direction and address.
        for (int combo = 0; combo < 8; combo++) begin
            do_reset();
            for (int a = 0; a < 32; a++) cmd1(1, 1'b0, a, 10'(a * 29 + 3));
            rx_burst = combo[0];
            tx_burst = combo[1];
            for (int a = 0; a < 32; a++) cmd1(combo[2] ? 0 : 1, 1'b0, a, 10'(a * 41 + combo * 7 + 1));
            for (int a = 0; a < 32; a++) cmd1(combo[2] ? 0 : 1, 1'b1, a, 10'(~(a * 13)));
            cmd1(combo[2] ? 0 : 1, 1'b1, 0, 10'h3ff);
            rx_burst = 1'b0; tx_burst = 1'b0;
        end

        // R8: same-address race, then different-address pair.
        do_reset();
        frame2(1'b1, 1'b1, {10'h155, 5'd5, 1'b0}, {10'h2aa, 5'd5, 1'b0}, ra, rb);
        chk(cfg_q[50 +: 10] == 10'h2aa, "R8 control wins", 32'(cfg_q[50 +: 10]), 32'h2aa);
        frame2(1'b1, 1'b1, {10'h0f1, 5'd7, 1'b0}, {10'h30e, 5'd9, 1'b0}, ra, rb);
        chk(cfg_q[70 +: 10] == 10'h0f1, "R8 data-path write kept", 32'(cfg_q[70 +: 10]), 32'h0f1);
        chk(cfg_q[90 +: 10] == 10'h30e, "R8 control write kept", 32'(cfg_q[90 +: 10]), 32'h30e);
        frame2(1'b1, 1'b1, {10'h3ff, 5'd5, 1'b1}, {10'h000, 5'd9, 1'b1}, ra, rb);
        frame2(1'b1, 1'b1, 16'h0, 16'h0, ra, rb);
        chk(ra == {10'h2aa, 5'd5, 1'b1}, "R3 dp read after race", 32'(ra), 32'({10'h2aa, 5'd5, 1'b1}));
        chk(rb == {10'h30e, 5'd9, 1'b1}, "R3 cp read", 32'(rb), 32'({10'h30e, 5'd9, 1'b1}));

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule